// File: doc/BRIEF.md
# Banked 64-bit Compare Timer

This block holds one free-running 64-bit up-counter that several cores share. Each core has its own bank: a 64-bit comparator, a 32-bit advance step, three control bits and a sticky event flag. A core's event fires when its comparator is armed and the shared count has reached or passed the comparator value. A core can also ask its comparator to move forward by the step after each event, so the block produces periodic ticks without software rewriting the comparator.

Software reaches the registers through a plain 32-bit register port. Every access carries a core index that picks the bank. Counter and prescaler state is the same whatever index is given. Each core has its own level interrupt line. Reads are combinational from the address and core index. Writes take effect at the clock edge on which select and write are both high.

Top module: `banked_cmp_timer`

## Requirements
- R1: While reset is asserted and after it, every readable register of every bank reads zero and every interrupt line is low.
- R2: With the counter stopped, a write to offset 0x00 loads the low 32 bits of the count and a write to offset 0x04 loads the high 32 bits. Both read back unchanged.
- R3: While the counter is running, writes to offsets 0x00 and 0x04 are ignored.
- R4: Control bits 15:8 hold a prescale value P, and the count advances once every P+1 clocks. Any write to control restarts the prescale phase. N clock edges after a control write that starts the counter, the count reads floor(N/(P+1)).
- R5: A carry out of the low half is visible in the high half on the same edge. The count 0x7_FFFFFFFF is followed by 0x8_00000000.
- R6: At offset 0x08, bit 0 (run) and bits 15:8 (prescale) are shared by all cores. Bit 1 (arm), bit 2 (interrupt enable) and bit 3 (auto-advance) belong to the addressed core alone.
- R7: The clock edge after the one on which an armed comparator first satisfies count >= comparator sets bit 0 of that core's status register at 0x0C. Equality is not required.
- R8: A comparator with its arm bit at 0 never sets the flag, even when the count is above it.
- R9: The flag is sticky. Writing 1 to status bit 0 clears it. Writing 0 leaves it alone. If the armed condition still holds, the flag is set again and a clear has no visible effect.
- R10: A core's interrupt line is high exactly while its flag is 1 and its interrupt-enable bit is 1.
- R11: With auto-advance on, each event adds the step at offset 0x18 to the 64-bit comparator at 0x10 (low) and 0x14 (high), with a carry into the high word. It keeps adding on successive edges while count >= comparator.
- R12: Writes to comparator, step, status and per-core control bits change only the bank named by the core index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_core | input | 1 | Bank (core) index of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr and reg_core |
| irq | output | 2 | One level interrupt per core |

## Verification
The bound checker watches every cycle for these properties: a stopped counter that is not being written holds still, and a running counter with no prescale steps by exactly one. A set flag stays set until a clear lands on its own bank. A flag can rise only when its comparator was armed. An interrupt line is never high without its flag. The exact cycle on which a flag rises, the floor(N/(P+1)) count for each prescale value, the sequence of comparator values under auto-advance and the isolation between banks are properties of a whole scenario. Only the bench's sweeps can show them, by comparing against arithmetic models.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_CNT_LO = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CNT_HI = 5'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_STAT   = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CMP_LO = 5'h10;
  localparam logic [REG_AW-1:0] OFS_CMP_HI = 5'h14;
  localparam logic [REG_AW-1:0] OFS_STEP   = 5'h18;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_ARM  = 1;
  localparam int unsigned CB_IEN  = 2;
  localparam int unsigned CB_AADV = 3;
  localparam int unsigned CB_PSC  = 8;
  localparam int unsigned PSC_W   = 8;

  typedef struct packed {
    logic arm;
    logic ien;
    logic aadv;
  } bank_ctl_t;
endpackage

// File: rtl/bct_count.sv
module bct_count #(
  parameter int unsigned DW    = 32,
  parameter int unsigned PSC_W = 8,
  localparam int unsigned CW   = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             run_wd,
  input  logic [PSC_W-1:0] psc_wd,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [DW-1:0]    wdata,
  output logic [CW-1:0]    cnt_q,
  output logic             run_q,
  output logic [PSC_W-1:0] psc_q
);
  logic [PSC_W-1:0] phase_q, phase_n, psc_n;
  logic [CW-1:0]    cnt_n;
  logic             run_n, tick;

  assign tick = run_q && (phase_q == psc_q);

  always_comb begin
    run_n   = run_q;
    psc_n   = psc_q;
    phase_n = phase_q;
    cnt_n   = cnt_q;
    if (run_q) begin
      phase_n = tick ? '0 : phase_q + 1'b1;
    end
    if (ctl_we) begin
      run_n   = run_wd;
      psc_n   = psc_wd;
      phase_n = '0;
    end
    if (tick) begin
      cnt_n = cnt_q + 1'b1;
    end else if (!run_q) begin
      if (lo_we) cnt_n[DW-1:0]  = wdata;
      if (hi_we) cnt_n[CW-1:DW] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      psc_q   <= '0;
      phase_q <= '0;
      cnt_q   <= '0;
    end else begin
      run_q   <= run_n;
      psc_q   <= psc_n;
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/bct_bank.sv
module bct_bank
  import bct_pkg::*;
#(
  parameter int unsigned DW  = 32,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          ctl_we,
  input  bank_ctl_t     ctl_wd,
  input  logic          clr_we,
  input  logic          cmp_lo_we,
  input  logic          cmp_hi_we,
  input  logic          step_we,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cmp_q,
  output logic [DW-1:0] step_q,
  output bank_ctl_t     ctl_q,
  output logic          flag_q,
  output logic          irq_o
);
  logic [CW-1:0] cmp_n;
  logic [DW-1:0] step_n;
  bank_ctl_t     ctl_n;
  logic          flag_n, hit;

  assign hit   = ctl_q.arm && (cnt >= cmp_q);
  assign irq_o = flag_q && ctl_q.ien;

  always_comb begin
    ctl_n  = ctl_we ? ctl_wd : ctl_q;
    step_n = step_we ? wdata : step_q;
    flag_n = hit || (flag_q && !clr_we);
    cmp_n  = cmp_q;
    if (hit && ctl_q.aadv) begin
      cmp_n = cmp_q + {{DW{1'b0}}, step_q};
    end
    if (cmp_lo_we) cmp_n[DW-1:0]  = wdata;
    if (cmp_hi_we) cmp_n[CW-1:DW] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      step_q <= '0;
      flag_q <= 1'b0;
      cmp_q  <= '0;
    end else begin
      ctl_q  <= ctl_n;
      step_q <= step_n;
      flag_q <= flag_n;
      cmp_q  <= cmp_n;
    end
  end
endmodule

// File: rtl/bct_rmux.sv
module bct_rmux
  import bct_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned PSC_W = 8,
  localparam int unsigned CW   = 2 * DW
) (
  input  logic [REG_AW-1:0] addr,
  input  logic              bank_ok,
  input  logic [CW-1:0]     cnt,
  input  logic              run,
  input  logic [PSC_W-1:0]  psc,
  input  bank_ctl_t         ctl,
  input  logic              flag,
  input  logic [CW-1:0]     cmp,
  input  logic [DW-1:0]     step,
  output logic [DW-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CNT_LO: rdata = cnt[DW-1:0];
      OFS_CNT_HI: rdata = cnt[CW-1:DW];
      OFS_CTRL: begin
        rdata[CB_RUN]                 = run;
        rdata[CB_PSC +: PSC_W]        = psc;
        rdata[CB_ARM]                 = bank_ok && ctl.arm;
        rdata[CB_IEN]                 = bank_ok && ctl.ien;
        rdata[CB_AADV]                = bank_ok && ctl.aadv;
      end
      OFS_STAT:   rdata[0] = bank_ok && flag;
      OFS_CMP_LO: rdata = bank_ok ? cmp[DW-1:0]  : '0;
      OFS_CMP_HI: rdata = bank_ok ? cmp[CW-1:DW] : '0;
      OFS_STEP:   rdata = bank_ok ? step : '0;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/banked_cmp_timer.sv
module banked_cmp_timer
  import bct_pkg::*;
#(
  parameter int unsigned NCORE = 2,
  parameter int unsigned DW    = 32,
  localparam int unsigned CW   = 2 * DW,
  localparam int unsigned CIW  = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CIW-1:0]    reg_core,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NCORE-1:0]  irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic we;
  logic we_ctl, we_stat, we_clo, we_chi, we_step, we_lo, we_hi;
  assign we      = reg_sel && reg_wr;
  assign we_ctl  = we && (reg_addr == OFS_CTRL);
  assign we_stat = we && (reg_addr == OFS_STAT) && reg_wdata[0];
  assign we_clo  = we && (reg_addr == OFS_CMP_LO);
  assign we_chi  = we && (reg_addr == OFS_CMP_HI);
  assign we_step = we && (reg_addr == OFS_STEP);
  assign we_lo   = we && (reg_addr == OFS_CNT_LO);
  assign we_hi   = we && (reg_addr == OFS_CNT_HI);

  logic [CW-1:0]    cnt_q;
  logic             run_q;
  logic [PSC_W-1:0] psc_q;

  bct_count #(.DW(DW), .PSC_W(PSC_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ctl_we (we_ctl),
    .run_wd (reg_wdata[CB_RUN]),
    .psc_wd (reg_wdata[CB_PSC +: PSC_W]),
    .lo_we  (we_lo),
    .hi_we  (we_hi),
    .wdata  (reg_wdata),
    .cnt_q  (cnt_q),
    .run_q  (run_q),
    .psc_q  (psc_q)
  );

  bank_ctl_t           ctl_wd;
  bank_ctl_t           b_ctl  [NCORE];
  logic [CW-1:0]       b_cmp  [NCORE];
  logic [DW-1:0]       b_step [NCORE];
  logic [NCORE-1:0]    b_flag;
  logic [NCORE-1:0]    b_arm;
  logic [NCORE-1:0]    b_ien;

  assign ctl_wd.arm  = reg_wdata[CB_ARM];
  assign ctl_wd.ien  = reg_wdata[CB_IEN];
  assign ctl_wd.aadv = reg_wdata[CB_AADV];

  for (genvar i = 0; i < NCORE; i++) begin : g_bank
    logic mine;
    assign mine = (reg_core == CIW'(i));

    bct_bank #(.DW(DW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .cnt       (cnt_q),
      .ctl_we    (we_ctl && mine),
      .ctl_wd    (ctl_wd),
      .clr_we    (we_stat && mine),
      .cmp_lo_we (we_clo && mine),
      .cmp_hi_we (we_chi && mine),
      .step_we   (we_step && mine),
      .wdata     (reg_wdata),
      .cmp_q     (b_cmp[i]),
      .step_q    (b_step[i]),
      .ctl_q     (b_ctl[i]),
      .flag_q    (b_flag[i]),
      .irq_o     (irq[i])
    );
    assign b_arm[i] = b_ctl[i].arm;
    assign b_ien[i] = b_ctl[i].ien;
  end

  logic          bank_ok;
  bank_ctl_t     sel_ctl;
  logic          sel_flag;
  logic [CW-1:0] sel_cmp;
  logic [DW-1:0] sel_step;

  always_comb begin
    bank_ok  = 1'b0;
    sel_ctl  = '0;
    sel_flag = 1'b0;
    sel_cmp  = '0;
    sel_step = '0;
    for (int i = 0; i < NCORE; i++) begin
      if (reg_core == CIW'(i)) begin
        bank_ok  = 1'b1;
        sel_ctl  = b_ctl[i];
        sel_flag = b_flag[i];
        sel_cmp  = b_cmp[i];
        sel_step = b_step[i];
      end
    end
  end

  bct_rmux #(.DW(DW), .PSC_W(PSC_W)) u_rmux (
    .addr    (reg_addr),
    .bank_ok (bank_ok),
    .cnt     (cnt_q),
    .run     (run_q),
    .psc     (psc_q),
    .ctl     (sel_ctl),
    .flag    (sel_flag),
    .cmp     (sel_cmp),
    .step    (sel_step),
    .rdata   (reg_rdata)
  );
endmodule

// File: rtl/bct_chk.sv
module bct_chk
  import bct_pkg::*;
#(
  parameter int unsigned NCORE = 2,
  parameter int unsigned DW    = 32,
  localparam int unsigned CW   = 2 * DW,
  localparam int unsigned CIW  = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [CIW-1:0]    reg_core,
  input logic [DW-1:0]     reg_wdata,
  input logic [CW-1:0]     cnt,
  input logic              run,
  input logic [PSC_W-1:0]  psc,
  input logic [NCORE-1:0]  flag,
  input logic [NCORE-1:0]  arm,
  input logic [NCORE-1:0]  irq
);
  logic cnt_wr;
  assign cnt_wr = reg_sel && reg_wr &&
                  ((reg_addr == OFS_CNT_LO) || (reg_addr == OFS_CNT_HI));

  // R2 R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && psc == '0) |=> (cnt == $past(cnt) + 1'b1));

  for (genvar i = 0; i < NCORE; i++) begin : g_c
    logic clr;
    assign clr = reg_sel && reg_wr && (reg_addr == OFS_STAT) &&
                 (reg_core == CIW'(i)) && reg_wdata[0];

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr) |=> flag[i]);

    // R8
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(arm[i]));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> flag[i]);
  end
endmodule

bind banked_cmp_timer bct_chk #(.NCORE(NCORE), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_core  (reg_core),
  .reg_wdata (reg_wdata),
  .cnt       (cnt_q),
  .run       (run_q),
  .psc       (psc_q),
  .flag      (b_flag),
  .arm       (b_arm),
  .irq       (irq)
);

// File: tb/sim_banked_cmp_timer.sv
module sim_banked_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_wr;
  logic [4:0]  reg_addr;
  logic [0:0]  reg_core;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  banked_cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_core(reg_core), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int core, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_core = 1'(core); reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input int core, input logic [4:0] a, output logic [31:0] d);
    reg_core = 1'(core); reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v, h;
    logic [63:0] c;
    reg_sel = 0; reg_wr = 0; reg_addr = 0; reg_core = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 2; k++)
      for (int a = 0; a <= 24; a += 4) begin
        rd(k, 5'(a), v); chk("R1 reset reg", v, 0);
      end
    chk("R1 reset irq", irq, 0);

    // R2 counter load while stopped
    wr(0, 5'h00, 32'hFFFF_FFFE);
    wr(0, 5'h04, 32'h7);
    rd(0, 5'h00, v); chk("R2 cnt lo", v, 32'hFFFF_FFFE);
    rd(1, 5'h04, v); chk("R2 cnt hi", v, 7);

    // R5 carry into high half
    wr(0, 5'h08, 32'h1);
    @(negedge clk);
    rd(0, 5'h00, v); rd(0, 5'h04, h); chk("R5 pre-carry", {h, v}, 64'h7_FFFF_FFFF);
    @(negedge clk);
    rd(0, 5'h00, v); rd(0, 5'h04, h); chk("R5 carry", {h, v}, 64'h8_0000_0000);

    // R3 write ignored while running
    wr(0, 5'h04, 32'h55);
    rd(0, 5'h04, v); chk("R3 hi ignored", v, 8);

    // R4 prescale sweep
    for (int p = 0; p < 4; p++) begin
      wr(0, 5'h08, 0);
      wr(0, 5'h00, 0);
      wr(0, 5'h04, 0);
      wr(0, 5'h08, (p << 8) | 1);
      rd(1, 5'h08, v); chk("R6 ctrl readback", v, (p << 8) | 1);
      for (int n = 1; n <= 12; n++) begin
        @(negedge clk);
        rd(0, 5'h00, v); chk("R4 prescaled count", v, n / (p + 1));
      end
    end

    // R6 / R12 shared and banked control bits
    wr(0, 5'h08, 0);
    wr(0, 5'h10, 32'hFFFF_FFFF);
    wr(0, 5'h14, 32'hFFFF_FFFF);
    wr(0, 5'h08, 32'hE);
    wr(1, 5'h08, 32'h1);
    rd(0, 5'h08, v); chk("R6 core0 ctrl", v, 32'hF);
    rd(1, 5'h08, v); chk("R6 core1 ctrl", v, 32'h1);
    rd(1, 5'h10, v); chk("R12 core1 cmp untouched", v, 0);
    wr(0, 5'h08, 0);

    // R8 disarmed comparator
    wr(0, 5'h00, 100);
    wr(0, 5'h04, 0);
    wr(0, 5'h10, 50);
    wr(0, 5'h14, 0);
    repeat (3) @(negedge clk);
    rd(0, 5'h0C, v); chk("R8 no event when disarmed", v, 0);

    // R7 arming, flag one edge later
    wr(0, 5'h08, 32'h2);
    rd(0, 5'h0C, v); chk("R7 flag not yet", v, 0);
    @(negedge clk);
    rd(0, 5'h0C, v); chk("R7 flag set on >=", v, 1);
    rd(1, 5'h0C, v); chk("R12 core1 flag clear", v, 0);

    // R9 sticky and clear
    wr(0, 5'h08, 0);
    rd(0, 5'h0C, v); chk("R9 sticky", v, 1);
    wr(0, 5'h0C, 0);
    rd(0, 5'h0C, v); chk("R9 write 0 no effect", v, 1);
    wr(1, 5'h0C, 1);
    rd(0, 5'h0C, v); chk("R12 other-bank clear", v, 1);
    wr(0, 5'h0C, 1);
    rd(0, 5'h0C, v); chk("R9 write 1 clears", v, 0);
    wr(0, 5'h08, 32'h2);
    @(negedge clk);
    wr(0, 5'h0C, 1);
    rd(0, 5'h0C, v); chk("R9 persists while condition holds", v, 1);

    // R10 interrupt gating
    chk("R10 irq off without enable", irq, 0);
    wr(0, 5'h08, 32'h6);
    chk("R10 irq with flag and enable", irq, 2'b01);
    wr(0, 5'h08, 32'h4);
    wr(0, 5'h0C, 1);
    chk("R10 irq drops with flag", irq, 0);
    wr(0, 5'h08, 0);

    // R7 exact event timing sweep
    for (int cv = 1; cv <= 7; cv += 2) begin
      wr(0, 5'h08, 0);
      wr(0, 5'h00, 0);
      wr(0, 5'h10, cv);
      wr(0, 5'h0C, 1);
      wr(0, 5'h08, 32'h3);
      rd(0, 5'h0C, v); chk("R7 timing n=0", v, 0);
      for (int n = 1; n <= cv + 2; n++) begin
        @(negedge clk);
        rd(0, 5'h0C, v); chk("R7 timing", v, (n >= cv + 1) ? 1 : 0);
      end
    end

    // R11 periodic advance, model per edge
    for (int p = 0; p < 2; p++) begin
      wr(0, 5'h08, 0);
      wr(0, 5'h0C, 1);
      wr(0, 5'h00, 0);
      wr(0, 5'h10, 5);
      wr(0, 5'h18, 4);
      wr(0, 5'h08, (p << 8) | 32'hB);
      c = 5;
      rd(0, 5'h10, v); chk("R11 cmp start", v, c);
      for (int n = 1; n <= 30; n++) begin
        @(negedge clk);
        if (64'((n - 1) / (p + 1)) >= c) c = c + 4;
        rd(0, 5'h10, v); chk("R11 cmp advance", v, c);
      end
    end

    // R11 carry into comparator high word
    wr(0, 5'h08, 0);
    wr(0, 5'h00, 0);
    wr(0, 5'h04, 1);
    wr(0, 5'h10, 32'hFFFF_FFFE);
    wr(0, 5'h14, 0);
    wr(0, 5'h18, 1);
    wr(0, 5'h08, 32'hA);
    repeat (5) @(negedge clk);
    rd(0, 5'h10, v); rd(0, 5'h14, h);
    chk("R11 cmp carry", {h, v}, 64'h1_0000_0001);

    // R1 reset mid-run
    wr(1, 5'h10, 32'h1234);
    rst_n = 0;
    #1;
    for (int k = 0; k < 2; k++)
      for (int a = 0; a <= 24; a += 4) begin
        rd(k, 5'(a), v); chk("R1 mid-run reset", v, 0);
      end
    chk("R1 mid-run irq", irq, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    finish_up();
  end
endmodule